// File: doc/BRIEF.md
# Synchronous Charge-Balance Pulse Modulator

This block is a digital model of a clocked voltage-to-frequency modulator. Each master clock cycle it converts an input code into a charge increment and adds it to an integrator. When the accumulated charge reaches a fixed threshold, the block subtracts one reference quantum from the integrator and raises its output for one clock period. The long-run pulse rate therefore rises linearly with the input. Zero scale gives one twentieth of the clock rate and full scale gives nine twentieths.

A mode bit selects how the input code is read. In unipolar mode the code is an unsigned fraction of the reference. In bipolar mode it is a two's complement value spanning minus to plus reference. A gain bit doubles the input, which halves the input span, and the block clamps any result that would fall outside the span. All four range settings map onto the same output rate limits. An active-low power-down input stops the modulator and holds its output low. When the block leaves power-down, the integrator starts again from zero. A downstream counter can count pulses over a gate window derived from the same clock, which gives a ratiometric conversion.

Top module: `vfm_modulator`

## Requirements
- R1: After reset, and again after each exit from power-down, `pulse_o` is low. The first pulse appears on active cycle ceil(T/inc), where T = 20·2^CODE_W and inc is the increment defined in R2.
- R2: The per-cycle increment is inc = 2^CODE_W + 8·v, where v in [0, 2^CODE_W] is the normalized input level. Starting from a cleared integrator with constant inputs, the number of pulses in the first N active cycles is exactly floor(N·inc/T).
- R3: In unipolar mode with gain 1 (`bipolar_i`=0, `gain2_i`=0), code 0 gives exactly one pulse every 20 cycles. This is the 5 % minimum rate.
- R4: In unipolar mode with gain 1, code 0x8000 (half reference) gives a rate of 1/4, and code 0x2000 (one eighth of reference) gives a rate of 1/10.
- R5: In unipolar mode with gain 1, code 0x4000 (one quarter of reference) gives an average rate of 3/20, and every spacing between successive pulses is 6 or 7 cycles.
- R6: In bipolar mode (`bipolar_i`=1) the code is two's complement and v = code·2^gain + 2^(CODE_W-1). With gain 1, code 0x8000 gives the 1/20 minimum, code 0x0000 gives 1/4, and code 0x7FFF gives just under 9/20.
- R7: With `gain2_i`=1 the input is doubled before v is clamped to [0, 2^CODE_W]. In unipolar mode, code 0x4000 gives 1/4, and code 0x8000 or above gives exactly 9/20. In bipolar mode, codes at or below 0xC000 give 1/20, and code 0x4000 gives 9/20.
- R8: While `pd_ni` is low, `pulse_o` stays low. On release, counting restarts from a cleared integrator, as stated in R2.
- R9: Each pulse lasts exactly one clock period, and `pulse_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Active-low power-down; low stops the modulator |
| bipolar_i | input | 1 | 0 = unsigned input code, 1 = two's complement input code |
| gain2_i | input | 1 | 1 = double the input (half span) |
| code_i | input | CODE_W | Input code |
| pulse_o | output | 1 | Output pulse train, one cycle per pulse |

## Verification
The bench predicts the exact pulse count for each run from the increment formula. A slope, offset or threshold that is off by one LSB therefore changes the count. The bench covers the quarter-scale spacing, and a comparator that used the wrong bound would produce gaps of 5 or 8. It exercises the bipolar offset and the clamps at both ends with gain 2. A missing clamp would wrap the level and give a near-minimum rate where the maximum is expected. It also checks the restart after power-down. A design that kept its residue would emit its first pulse early and miscount the run.

// File: rtl/vfm_pkg.sv
package vfm_pkg;

   // Rates are expressed in twentieths of the clock rate.
   localparam int unsigned ZERO_SCALE_PARTS = 1;
   localparam int unsigned FULL_SCALE_PARTS = 9;
   localparam int unsigned THRESH_PARTS     = 20;
   localparam int unsigned SPAN_PARTS       = FULL_SCALE_PARTS - ZERO_SCALE_PARTS;

   typedef enum logic {
      MODE_UNIPOLAR = 1'b0,
      MODE_BIPOLAR  = 1'b1
   } vfm_mode_e;

endpackage

// File: rtl/vfm_range_map.sv
module vfm_range_map
   import vfm_pkg::*;
#(
   parameter int unsigned CODE_W = 16,
   localparam int unsigned LVL_W = CODE_W + 1
) (
   input  logic [CODE_W-1:0] code_i,
   input  vfm_mode_e         mode_i,
   input  logic              gain2_i,
   output logic [LVL_W-1:0]  level_o
);

   localparam int unsigned EXT_W = CODE_W + 3;
   localparam logic signed [EXT_W-1:0] ONE_X  = {{(EXT_W-1){1'b0}}, 1'b1};
   localparam logic signed [EXT_W-1:0] HALF_X = ONE_X <<< (CODE_W - 1);
   localparam logic signed [EXT_W-1:0] FULL_X = ONE_X <<< CODE_W;

   logic signed [EXT_W-1:0] ext_code;
   logic signed [EXT_W-1:0] scaled [2];
   logic signed [EXT_W-1:0] lifted;

   always_comb begin
      if (mode_i == MODE_BIPOLAR) begin
         ext_code = signed'({{3{code_i[CODE_W-1]}}, code_i});
      end else begin
         ext_code = signed'({3'b000, code_i});
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_gain
      assign scaled[g] = ext_code <<< g;
   end

   always_comb begin
      lifted = gain2_i ? scaled[1] : scaled[0];
      if (mode_i == MODE_BIPOLAR) begin
         lifted = lifted + HALF_X;
      end
      if (lifted < 0) begin
         level_o = '0;
      end else if (lifted > FULL_X) begin
         level_o = FULL_X[LVL_W-1:0];
      end else begin
         level_o = lifted[LVL_W-1:0];
      end
   end

endmodule

// File: rtl/vfm_increment.sv
module vfm_increment
   import vfm_pkg::*;
#(
   parameter int unsigned CODE_W = 16,
   localparam int unsigned LVL_W = CODE_W + 1,
   localparam int unsigned ACC_W = CODE_W + $clog2(THRESH_PARTS + FULL_SCALE_PARTS)
) (
   input  logic [LVL_W-1:0] level_i,
   output logic [ACC_W-1:0] inc_o
);

   localparam logic [ACC_W-1:0] ZERO_BASE  = ACC_W'(ZERO_SCALE_PARTS) << CODE_W;
   localparam bit               SPAN_POW2  = (SPAN_PARTS & (SPAN_PARTS - 1)) == 0;
   localparam int unsigned      SPAN_SHIFT = $clog2(SPAN_PARTS);

   logic [ACC_W-1:0] span_term;

   if (SPAN_POW2) begin : g_shift
      assign span_term = ACC_W'(level_i) << SPAN_SHIFT;
   end else begin : g_mult
      assign span_term = ACC_W'(level_i) * ACC_W'(SPAN_PARTS);
   end

   assign inc_o = ZERO_BASE + span_term;

endmodule

// File: rtl/vfm_integrator.sv
module vfm_integrator
   import vfm_pkg::*;
#(
   parameter int unsigned CODE_W = 16,
   localparam int unsigned ACC_W = CODE_W + $clog2(THRESH_PARTS + FULL_SCALE_PARTS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [ACC_W-1:0] inc_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             pulse_o
);

   localparam logic [ACC_W-1:0] THRESH = ACC_W'(THRESH_PARTS) << CODE_W;

   logic             wake_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] base;
   logic [ACC_W-1:0] sum;
   logic             hit;

   assign base = wake_q ? '0 : acc_q;
   assign sum  = base + inc_i;
   assign hit  = sum >= THRESH;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q   <= '0;
         wake_q  <= 1'b1;
         pulse_o <= 1'b0;
      end else if (!run_i) begin
         wake_q  <= 1'b1;
         pulse_o <= 1'b0;
      end else begin
         wake_q  <= 1'b0;
         acc_q   <= hit ? (sum - THRESH) : sum;
         pulse_o <= hit;
      end
   end

   assign acc_o = wake_q ? '0 : acc_q;

endmodule

// File: rtl/vfm_modulator.sv
module vfm_modulator
   import vfm_pkg::*;
#(
   parameter int unsigned CODE_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pd_ni,
   input  logic              bipolar_i,
   input  logic              gain2_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              pulse_o
);

   localparam int unsigned LVL_W = CODE_W + 1;
   localparam int unsigned ACC_W = CODE_W + $clog2(THRESH_PARTS + FULL_SCALE_PARTS);

   if (CODE_W < 4 || CODE_W > 28) begin : g_bad_width
      $error("vfm_modulator: CODE_W must lie in 4..28");
   end
   if (2 * FULL_SCALE_PARTS >= THRESH_PARTS) begin : g_bad_rate
      $error("vfm_modulator: full-scale rate must stay below half the clock");
   end

   vfm_mode_e        mode;
   logic [LVL_W-1:0] level;
   logic [ACC_W-1:0] inc;
   logic [ACC_W-1:0] acc_level;

   assign mode = bipolar_i ? MODE_BIPOLAR : MODE_UNIPOLAR;

   vfm_range_map #(.CODE_W(CODE_W)) u_range (
      .code_i  (code_i),
      .mode_i  (mode),
      .gain2_i (gain2_i),
      .level_o (level)
   );

   vfm_increment #(.CODE_W(CODE_W)) u_inc (
      .level_i (level),
      .inc_o   (inc)
   );

   vfm_integrator #(.CODE_W(CODE_W)) u_integ (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (pd_ni),
      .inc_i   (inc),
      .acc_o   (acc_level),
      .pulse_o (pulse_o)
   );

endmodule

// File: rtl/vfm_modulator_chk.sv
module vfm_modulator_chk
   import vfm_pkg::*;
#(
   parameter int unsigned CODE_W = 16,
   localparam int unsigned LVL_W = CODE_W + 1,
   localparam int unsigned ACC_W = CODE_W + $clog2(THRESH_PARTS + FULL_SCALE_PARTS)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             pd_ni,
   input logic             pulse_o,
   input logic [LVL_W-1:0] level,
   input logic [ACC_W-1:0] inc,
   input logic [ACC_W-1:0] acc_level
);

   localparam logic [ACC_W-1:0] THRESH   = ACC_W'(THRESH_PARTS) << CODE_W;
   localparam logic [ACC_W-1:0] INC_MIN  = ACC_W'(ZERO_SCALE_PARTS) << CODE_W;
   localparam logic [ACC_W-1:0] INC_MAX  = ACC_W'(FULL_SCALE_PARTS) << CODE_W;
   localparam logic [LVL_W-1:0] LVL_FULL = {1'b1, {CODE_W{1'b0}}};

   // R9
   no_back2back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o |=> !pulse_o);

   // R8
   pd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pd_ni |=> !pulse_o);

   // R1
   wake_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pd_ni && !$past(pd_ni)) |=> !pulse_o);

   // R2
   acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_level < THRESH);

   // R2
   inc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc >= INC_MIN) && (inc <= INC_MAX));

   // R7
   level_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level <= LVL_FULL);

endmodule

bind vfm_modulator vfm_modulator_chk #(.CODE_W(CODE_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .pd_ni     (pd_ni),
   .pulse_o   (pulse_o),
   .level     (level),
   .inc       (inc),
   .acc_level (acc_level)
);

// File: tb/test_vfm_modulator.sv
module test_vfm_modulator;

   localparam int unsigned CODE_W = 16;
   localparam longint      ONE    = longint'(1) << CODE_W;
   localparam longint      THRESH = 20 * ONE;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pd_n = 1'b0;
   logic              bip = 1'b0;
   logic              g2 = 1'b0;
   logic [CODE_W-1:0] code = '0;
   logic              pulse;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   vfm_modulator #(.CODE_W(CODE_W)) i_vfm_modulator (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .pd_ni     (pd_n),
      .bipolar_i (bip),
      .gain2_i   (g2),
      .code_i    (code),
      .pulse_o   (pulse)
   );

   function automatic longint exp_inc(bit b, bit g, logic [CODE_W-1:0] c);
      longint s;
      longint v;
      s = b ? longint'($signed(c)) : longint'(c);
      v = (g ? 2 * s : s) + (b ? ONE / 2 : 0);
      if (v < 0) v = 0;
      if (v > ONE) v = ONE;
      return ONE + 8 * v;
   endfunction

   task automatic check(string tag, longint act, longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic run_case(string tag, bit b, bit g, logic [CODE_W-1:0] c,
                           int n, bit want_gap67);
      longint inc;
      int cnt;
      int first;
      int last;
      int back2back;
      int bad_gap;
      bit prev;
      inc = exp_inc(b, g, c);
      @(negedge clk);
      pd_n = 1'b0; bip = b; g2 = g; code = c;
      @(negedge clk);
      pd_n = 1'b1;
      cnt = 0; first = -1; last = -1; back2back = 0; bad_gap = 0; prev = 1'b0;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (pulse) begin
            cnt++;
            if (first < 0) first = k;
            if (prev) back2back++;
            if (last >= 0 && want_gap67 && (k - last != 6) && (k - last != 7))
               bad_gap++;
            last = k;
         end
         prev = pulse;
      end
      check({tag, " count"}, cnt, (longint'(n) * inc) / THRESH);
      check({"R1 first pulse (", tag, ")"}, first, (THRESH + inc - 1) / inc);
      check({"R9 back-to-back (", tag, ")"}, back2back, 0);
      if (want_gap67) check({tag, " spacing not 6/7"}, bad_gap, 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seen;
      void'($urandom(32'd1234));
      // R1 reset state
      #5;
      check("R1 pulse during reset", pulse, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (pulse) seen++;
      end
      check("R1 quiet after reset in power-down", seen, 0);

      run_case("R3 uni zero", 1'b0, 1'b0, 16'h0000, 400, 1'b0);
      run_case("R4 uni half", 1'b0, 1'b0, 16'h8000, 400, 1'b0);
      run_case("R4 uni eighth", 1'b0, 1'b0, 16'h2000, 400, 1'b0);
      run_case("R5 uni quarter", 1'b0, 1'b0, 16'h4000, 400, 1'b1);
      run_case("R6 bip min", 1'b1, 1'b0, 16'h8000, 400, 1'b0);
      run_case("R6 bip zero", 1'b1, 1'b0, 16'h0000, 400, 1'b0);
      run_case("R6 bip max", 1'b1, 1'b0, 16'h7FFF, 400, 1'b0);
      run_case("R7 uni g2 quarter", 1'b0, 1'b1, 16'h4000, 400, 1'b0);
      run_case("R7 uni g2 half", 1'b0, 1'b1, 16'h8000, 400, 1'b0);
      run_case("R7 uni g2 top", 1'b0, 1'b1, 16'hFFFF, 400, 1'b0);
      run_case("R7 bip g2 low", 1'b1, 1'b1, 16'hC000, 400, 1'b0);
      run_case("R7 bip g2 min", 1'b1, 1'b1, 16'h8000, 400, 1'b0);
      run_case("R7 bip g2 high", 1'b1, 1'b1, 16'h4000, 400, 1'b0);

      // R8 power-down mid-run at the maximum rate
      @(negedge clk);
      pd_n = 1'b1; bip = 1'b0; g2 = 1'b1; code = 16'hFFFF;
      repeat (13) @(negedge clk);
      pd_n = 1'b0;
      @(negedge clk);
      seen = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (pulse) seen++;
      end
      check("R8 pulses while powered down", seen, 0);
      run_case("R8 restart after power-down", 1'b0, 1'b1, 16'hFFFF, 200, 1'b0);

      // R2 random codes and modes
      for (int i = 0; i < 24; i++) begin
         logic [CODE_W-1:0] rc;
         bit rb;
         bit rg;
         int rn;
         rc = CODE_W'($urandom);
         rb = 1'($urandom);
         rg = 1'($urandom);
         rn = 200 + int'($urandom_range(0, 400));
         run_case("R2 random", rb, rg, rc, rn, 1'b0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule